// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a free-running down-counter that produces a steady time base for an operating-system scheduler. Software programs a 24-bit reload value, selects whether the counter advances on every core clock or only on cycles where an external slow reference strobe is high, and sets the enable bit. The counter then counts down, reloads itself, and repeats with a period of reload+1 counting ticks.

Each time the count reaches zero, a sticky wrap flag is set and, if enabled, a one-cycle exception request pulse goes to the interrupt controller. The flag clears when software reads the control register, so a polling loop can detect a wrap. Any write to the current-value register restarts the count. A reload value of zero makes the counter stop by itself after its next wrap.

Access uses a single-cycle valid/write strobe on a 32-bit data path. Read data is registered and returned one cycle after the request, with a matching valid pulse.

Top module: `tick_timer`

## Requirements
- R1: After reset, control, reload and current value all read zero, and both the exception request and the read data are low.
- R2: A write to control (offset 0x10) updates only bits 2:0: bit 0 run, bit 1 exception enable, bit 2 source select. Data in the other bits is ignored. The wrap flag at bit 16 keeps its value across the write. All other control bits read as zero.
- R3: A read of control returns the wrap flag as it stood before the read, then clears the flag. If a wrap happens in the same cycle as the read, the flag ends up set.
- R4: With source select 1, the counter decrements on every clock. A move from 1 to 0 sets the wrap flag. The tick after that loads the reload value, so one period is reload+1 clocks.
- R5: When the count moves from 1 to 0 and the exception enable is 1, `tick_irq` is high for exactly one cycle, the cycle after that tick. With the enable at 0 it stays low.
- R6: With source select 0, the counter changes only on clocks where `ref_tick_en` is high, and holds its value otherwise.
- R7: When a tick finds the count at zero and the reload value at zero, the run bit clears and counting stops.
- R8: Any write to the current-value register (offset 0x18) loads the reload value into the counter, whatever the data, and clears the wrap flag.
- R9: The current-value register reads zero while the run bit is 0.
- R10: The calibration register (offset 0x1C) always reads 10000 decimal. Writes to it have no effect.
- R11: The reload register (offset 0x14) stores only data bits 23:0. Bits 31:24 read as zero.
- R12: Read data appears in the cycle after the request, together with `bus_rvalid`. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| ref_tick_en | input | 1 | Slow reference strobe, one clock wide per reference tick |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| tick_irq | output | 1 | One-cycle exception request on wrap |

## Verification
The hardest case to reach from the ports is a wrap that falls in the same cycle as a read of the control register. The set has to win over the clear-on-read, and it has to stay visible to the next read. The stimulus restarts the count from a known reload value with a current-value write, enables the core-clock source, and counts the idle cycles exactly, so the control read lands on the wrap tick. Reads just before and just after that tick confirm which way the conflict went. The same cycle counting places reads on each side of the self-stop caused by a zero reload value.

// File: rtl/tick_pkg.sv
package tick_pkg;

  localparam int OFS_CTRL    = 'h10;
  localparam int OFS_RELOAD  = 'h14;
  localparam int OFS_CURRENT = 'h18;
  localparam int OFS_CALIB   = 'h1C;

  localparam int BIT_RUN   = 0;
  localparam int BIT_IEN   = 1;
  localparam int BIT_SRC   = 2;
  localparam int BIT_FLAG  = 16;
  localparam int CTRL_WBITS = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_CURRENT,
    SEL_CALIB
  } reg_sel_e;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/tick_decode.sv
module tick_decode
  import tick_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              wr_ctrl,
  output logic              wr_reload,
  output logic              wr_cur,
  output logic              rd_ctrl,
  output logic              rd_any
);

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFS_CTRL):    sel = SEL_CTRL;
      ADDR_W'(OFS_RELOAD):  sel = SEL_RELOAD;
      ADDR_W'(OFS_CURRENT): sel = SEL_CURRENT;
      ADDR_W'(OFS_CALIB):   sel = SEL_CALIB;
      default:              sel = SEL_NONE;
    endcase
  end

  assign wr_ctrl   = bus_valid &  bus_write & (sel == SEL_CTRL);
  assign wr_reload = bus_valid &  bus_write & (sel == SEL_RELOAD);
  assign wr_cur    = bus_valid &  bus_write & (sel == SEL_CURRENT);
  assign rd_ctrl   = bus_valid & ~bus_write & (sel == SEL_CTRL);
  assign rd_any    = bus_valid & ~bus_write;

endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_ctrl,
  input  logic [CTRL_WBITS-1:0] wbits,
  input  logic                  rd_ctrl,
  input  logic                  wr_cur,
  input  logic                  fire,
  input  logic                  auto_stop,
  output ctrl_t                 ctrl_q,
  output logic                  flag_q
);

  // run bit: a bus write wins over the self-stop in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.run      <= wbits[BIT_RUN];
      ctrl_q.irq_en   <= wbits[BIT_IEN];
      ctrl_q.src_core <= wbits[BIT_SRC];
    end else if (auto_stop) begin
      ctrl_q.run <= 1'b0;
    end
  end

  // sticky wrap flag: a new wrap wins over any clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (fire) begin
      flag_q <= 1'b1;
    end else if (rd_ctrl || wr_cur) begin
      flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tick_count.sv
module tick_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_reload,
  input  logic             wr_cur,
  input  logic [CNT_W-1:0] wdata,
  input  logic             run,
  input  logic             src_core,
  input  logic             ref_tick_en,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] cur_q,
  output logic             fire,
  output logic             auto_stop
);

  logic step;
  logic at_zero;
  logic at_one;
  logic reload_zero;

  assign step        = run & (src_core | ref_tick_en) & ~wr_cur;
  assign at_zero     = (cur_q == '0);
  assign at_one      = (cur_q == CNT_W'(1));
  assign reload_zero = (reload_q == '0);
  assign fire        = step & at_one;
  assign auto_stop   = step & at_zero & reload_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
    end else if (wr_reload) begin
      reload_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
    end else if (wr_cur) begin
      cur_q <= reload_q;
    end else if (step) begin
      if (at_zero) begin
        if (!reload_zero) begin
          cur_q <= reload_q;
        end
      end else begin
        cur_q <= cur_q - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/tick_rdmux.sv
module tick_rdmux
  import tick_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 24,
  parameter int CALIB_VAL = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_any,
  input  reg_sel_e          sel,
  input  ctrl_t             ctrl_q,
  input  logic              flag_q,
  input  logic [CNT_W-1:0]  reload_q,
  input  logic [CNT_W-1:0]  cur_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    unique case (sel)
      SEL_CTRL: begin
        rd_next[BIT_RUN]  = ctrl_q.run;
        rd_next[BIT_IEN]  = ctrl_q.irq_en;
        rd_next[BIT_SRC]  = ctrl_q.src_core;
        rd_next[BIT_FLAG] = flag_q;
      end
      SEL_RELOAD:  rd_next[CNT_W-1:0] = reload_q;
      SEL_CURRENT: rd_next[CNT_W-1:0] = ctrl_q.run ? cur_q : '0;
      SEL_CALIB:   rd_next = DATA_W'(CALIB_VAL);
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_any;
      if (rd_any) begin
        rdata_q <= rd_next;
      end
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 24,
  parameter int CALIB_VAL = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ref_tick_en,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              tick_irq
);

  reg_sel_e         sel;
  logic             wr_ctrl;
  logic             wr_reload;
  logic             wr_cur;
  logic             rd_ctrl;
  logic             rd_any;
  ctrl_t            ctrl_q;
  logic             flag_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cur_q;
  logic             fire;
  logic             auto_stop;
  logic             irq_q;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

  tick_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .sel       (sel),
    .wr_ctrl   (wr_ctrl),
    .wr_reload (wr_reload),
    .wr_cur    (wr_cur),
    .rd_ctrl   (rd_ctrl),
    .rd_any    (rd_any)
  );

  tick_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (wr_ctrl),
    .wbits     (bus_wdata[CTRL_WBITS-1:0]),
    .rd_ctrl   (rd_ctrl),
    .wr_cur    (wr_cur),
    .fire      (fire),
    .auto_stop (auto_stop),
    .ctrl_q    (ctrl_q),
    .flag_q    (flag_q)
  );

  tick_count #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rst         (rst),
    .wr_reload   (wr_reload),
    .wr_cur      (wr_cur),
    .wdata       (bus_wdata[CNT_W-1:0]),
    .run         (ctrl_q.run),
    .src_core    (ctrl_q.src_core),
    .ref_tick_en (ref_tick_en),
    .reload_q    (reload_q),
    .cur_q       (cur_q),
    .fire        (fire),
    .auto_stop   (auto_stop)
  );

  tick_rdmux #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CALIB_VAL(CALIB_VAL)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_any   (rd_any),
    .sel      (sel),
    .ctrl_q   (ctrl_q),
    .flag_q   (flag_q),
    .reload_q (reload_q),
    .cur_q    (cur_q),
    .rdata_q  (bus_rdata),
    .rvalid_q (bus_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= fire & ctrl_q.irq_en;
    end
  end

  assign tick_irq = irq_q;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 24,
  parameter int CALIB_VAL = 10000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tick_irq,
  input logic              flag,
  input logic              run,
  input logic [CNT_W-1:0]  cur,
  input logic [CNT_W-1:0]  reload,
  input logic              wr_cur,
  input logic              wr_ctrl,
  input logic              fire
);

  logic rd_calib;
  assign rd_calib = bus_valid & ~bus_write & (bus_addr == ADDR_W'(tick_pkg::OFS_CALIB));

  // R5: request is a single-cycle pulse
  p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
    tick_irq |=> !tick_irq);

  // R5: a request always comes with the wrap flag set
  p_irq_flag_r5: assert property (@(posedge clk) disable iff (rst)
    tick_irq |-> flag);

  // R8: current-value write restarts from reload and clears the flag
  p_cur_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_cur)) |-> (cur == $past(reload) && !flag));

  // R6: a stopped counter holds its value
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(run) && !$past(wr_cur)) |-> $stable(cur));

  // R2: control writes leave the flag alone
  p_ctrl_keeps_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_ctrl) && !$past(fire)) |-> (flag == $past(flag)));

  // R7: self-stop only from zero count with zero reload
  p_self_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run) && !run && !$past(wr_ctrl))
      |-> ($past(cur) == '0 && $past(reload) == '0));

  // R10: calibration constant on read
  p_calib_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_calib)) |-> (bus_rdata == DATA_W'(CALIB_VAL)));

endmodule

bind tick_timer tick_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CALIB_VAL(CALIB_VAL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .tick_irq  (tick_irq),
  .flag      (flag_q),
  .run       (ctrl_q.run),
  .cur       (cur_q),
  .reload    (reload_q),
  .wr_cur    (wr_cur),
  .wr_ctrl   (wr_ctrl),
  .fire      (fire)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_REL  = 8'h14;
  localparam logic [7:0] A_CUR  = 8'h18;
  localparam logic [7:0] A_CAL  = 8'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        ref_tick_en = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        tick_irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer dut_i (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ref_tick_en (ref_tick_en),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .tick_irq    (tick_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; ref_tick_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0; ref_tick_en = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input logic ref_en, input logic exp_irq, input string tag);
    @(negedge clk);
    check(tag, {31'b0, tick_irq}, {31'b0, exp_irq});
    bus_valid = 1'b0; bus_write = 1'b0; ref_tick_en = ref_en;
  endtask

  // monitor: pops the expected read result as the design returns it (R12)
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R12: unexpected read data 0x%08h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 irq", {31'b0, tick_irq}, 32'h0);
    bus_rd(A_CTRL, 32'h0, "R1 ctrl");
    bus_rd(A_CUR,  32'h0, "R1 cur");
    bus_rd(A_REL,  32'h0, "R1 reload");
    // calibration and unmapped offsets
    bus_rd(A_CAL, 32'd10000, "R10 calib");
    bus_wr(A_CAL, 32'h0);
    bus_rd(A_CAL, 32'd10000, "R10 calib after write");
    bus_rd(8'h20, 32'h0, "R12 unmapped");
    bus_rd(8'h00, 32'h0, "R12 unmapped");
    // reload width
    bus_wr(A_REL, 32'hFFFF_FFFF);
    bus_rd(A_REL, 32'h00FF_FFFF, "R11 reload width");
    // disabled current value
    bus_wr(A_REL, 32'd5);
    bus_wr(A_CUR, 32'h1234);
    bus_rd(A_CUR, 32'h0, "R9 disabled");
    // core-clock counting, period reload+1
    bus_wr(A_CTRL, 32'h5);
    bus_rd(A_CUR, 32'd5, "R4 count");
    bus_rd(A_CUR, 32'd4, "R4 count");
    repeat (3) idle(1'b0, 1'b0, "R5 no irq when disabled");
    bus_rd(A_CTRL, 32'h0001_0005, "R3 flag read");
    bus_rd(A_CTRL, 32'h0000_0005, "R3 flag cleared");
    repeat (2) idle(1'b0, 1'b0, "R5 no irq when disabled");
    bus_rd(A_CTRL, 32'h0000_0005, "R4 before second wrap");
    idle(1'b0, 1'b0, "R5 no irq when disabled");
    bus_rd(A_CTRL, 32'h0001_0005, "R4 second wrap");
    // exception pulse
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_CUR, 32'h0);
    bus_wr(A_CTRL, 32'h7);
    repeat (5) idle(1'b0, 1'b0, "R5 before wrap");
    idle(1'b0, 1'b1, "R5 pulse");
    idle(1'b0, 1'b0, "R5 pulse ends");
    bus_wr(A_CTRL, 32'hFFFF_FFF8);
    bus_rd(A_CTRL, 32'h0001_0000, "R2 write keeps flag");
    // reference strobe source
    bus_wr(A_REL, 32'd3);
    bus_wr(A_CUR, 32'h0);
    bus_wr(A_CTRL, 32'h1);
    repeat (3) idle(1'b0, 1'b0, "R5 irq off");
    bus_rd(A_CUR, 32'd3, "R6 hold without strobe");
    repeat (2) idle(1'b1, 1'b0, "R5 irq off");
    bus_rd(A_CUR, 32'd1, "R6 two strobes");
    idle(1'b1, 1'b0, "R5 irq off");
    idle(1'b0, 1'b0, "R5 irq off");
    // restart by current-value write
    bus_wr(A_CUR, 32'h00AB_CDEF);
    bus_rd(A_CTRL, 32'h0000_0001, "R8 flag cleared");
    bus_rd(A_CUR, 32'd3, "R8 restart value");
    // zero reload self-stop
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_REL, 32'd2);
    bus_wr(A_CUR, 32'h0);
    bus_wr(A_REL, 32'd0);
    bus_wr(A_CTRL, 32'h5);
    repeat (3) idle(1'b0, 1'b0, "R5 irq off");
    bus_rd(A_CTRL, 32'h0001_0004, "R7 stopped");
    bus_rd(A_CTRL, 32'h0000_0004, "R7 stays stopped");
    bus_rd(A_CUR, 32'h0, "R9 after stop");
    // wrap coincides with control read
    bus_wr(A_REL, 32'd5);
    bus_wr(A_CUR, 32'h0);
    bus_wr(A_CTRL, 32'h5);
    repeat (4) idle(1'b0, 1'b0, "R5 irq off");
    bus_rd(A_CTRL, 32'h0000_0005, "R3 read on wrap tick");
    bus_rd(A_CTRL, 32'h0001_0005, "R3 set wins");
    bus_rd(A_CTRL, 32'h0000_0005, "R3 cleared after");
    repeat (3) idle(1'b0, 1'b0, "R5 irq off");
    check("R12 all reads returned", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule